// File: doc/BRIEF.md
# Multislot Allocation Rule Checker

This block judges, once per TDMA frame, whether a proposed slot allocation is one a handset of a given multislot class can actually serve. It takes an eight-slot receive bitmap, an eight-slot transmit bitmap and a numeric class code. It places the transmit slots on a common timeline, where the uplink runs three slot periods behind the downlink. It then checks the receive count, the transmit count, the combined count and the idle turnaround gaps in both directions against the class limits.

The checker also decides whether the frame leaves room for a neighbour-cell measurement. A measurement needs an idle slot, and one of the two turnarounds must be long enough to hold it. When a window is granted, the checker reports the slot index of that window. It also steps a monitor counter that cycles through the serving cell and five neighbours. Every result is registered on a frame strobe and holds until the next strobe.

Top module: `msl_alloc_check`

## Requirements
- R1: Transmit slot k falls on common-timeline slot (k+3) mod 8. Receive slot k falls on timeline slot k. A turnaround gap is the number of timeline slots between the two activities, counted modulo 8, so a gap may wrap into the next frame.
- R2: The receive and transmit limits per class are: class 2 is 2/1, class 4 is 3/1, class 8 is 4/1, class 10 is 4/2, class 12 is 4/4. Exceeding the receive limit sets viol bit 0. Exceeding the transmit limit sets viol bit 1.
- R3: The combined receive plus transmit count may not exceed 3 for class 2, 4 for class 4, and 5 for classes 8, 10 and 12. Exceeding it sets viol bit 2.
- R4: Every transmit activity that follows a receive activity needs at least the short rx-to-tx gap. That gap is 2 slots for class 2 and 1 slot for the other classes. A receive and a transmit on the same timeline slot count as a gap below any limit. A failure sets viol bit 3.
- R5: Every receive activity that follows a transmit activity needs at least the short tx-to-rx gap of 1 slot. A failure sets viol bit 4.
- R6: A measurement window is granted when three conditions hold: the class is supported, at least one timeline slot is idle, and one of two gap pairings is met. The first pairing is the long rx-to-tx gap with the short tx-to-rx gap. The second pairing is the short rx-to-tx gap with the long tx-to-rx gap. The long gaps (rx-to-tx, tx-to-rx) are 3/3 for classes 2 and 4, 3/2 for classes 8 and 10, and 2/2 for class 12. no_window is high exactly when no window is granted.
- R7: With a window granted, meas_slot is the lowest idle timeline slot index. Without a window, meas_slot is 0.
- R8: meas_cell starts at 0. On a strobe that grants a window it steps by one and wraps from 5 to 0. On a strobe that grants no window it is unchanged.
- R9: A class code other than 2, 4, 8, 10 or 12 gives alloc_ok low, viol = 6'b100000 (bit 5 only) and no_window high.
- R10: alloc_ok is high exactly when the class is supported and viol bits 0 to 4 are all clear.
- R11: After reset, all outputs are 0. Outputs change only at a clock edge where frame_stb is high, and show that edge's inputs one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Evaluate the inputs and register the results |
| class_code | input | 5 | Multislot class number |
| rx_map | input | 8 | Receive slots, bit k = downlink slot k |
| tx_map | input | 8 | Transmit slots, bit k = uplink slot k |
| alloc_ok | output | 1 | Allocation legal for the class |
| viol | output | 6 | Violations: 0 rx, 1 tx, 2 sum, 3 rx-to-tx gap, 4 tx-to-rx gap, 5 unknown class |
| no_window | output | 1 | No measurement window this frame |
| meas_slot | output | 3 | Timeline slot of the granted window |
| meas_cell | output | 3 | Monitor index, 0 to 5 |

## Verification
Most of the state is recomputed from scratch on every strobe. A wrong gap or count path therefore shows up in viol and alloc_ok one cycle after the strobe that exposes it. The sweep covers every receive bitmap against many transmit bitmaps for each class, so a wrong shift, wrap or limit shows up within a few hundred strobes. The only long-lived state is the monitor counter. An error there, whether a missed step, a step without a window or a wrong wrap point, shows up in meas_cell on the next strobe and stays visible in every later compare.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int MSL_SLOTS = 8;
  localparam int MSL_CNT_W = 4;
  localparam int MSL_GAP_W = 3;

  localparam int V_RX  = 0;
  localparam int V_TX  = 1;
  localparam int V_SUM = 2;
  localparam int V_RT  = 3;
  localparam int V_TR  = 4;
  localparam int V_CLS = 5;
  localparam int V_W   = 6;

  typedef struct packed {
    logic                 known;
    logic [MSL_CNT_W-1:0] rx_max;
    logic [MSL_CNT_W-1:0] tx_max;
    logic [MSL_CNT_W-1:0] sum_max;
    logic [MSL_GAP_W-1:0] rt_long;
    logic [MSL_GAP_W-1:0] rt_short;
    logic [MSL_GAP_W-1:0] tr_long;
    logic [MSL_GAP_W-1:0] tr_short;
  } msl_limits_t;

  function automatic logic [MSL_CNT_W-1:0] msl_popcnt(input logic [MSL_SLOTS-1:0] m);
    logic [MSL_CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < MSL_SLOTS; i++) c = c + MSL_CNT_W'(m[i]);
    return c;
  endfunction
endpackage

// File: rtl/msl_class_rom.sv
module msl_class_rom
  import msl_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0] class_code,
  output msl_limits_t   lim
);
  function automatic msl_limits_t mk(input int rx, input int tx, input int sm,
                                     input int ta, input int tb, input int ra, input int rb);
    msl_limits_t e;
    e.known    = 1'b1;
    e.rx_max   = MSL_CNT_W'(rx);
    e.tx_max   = MSL_CNT_W'(tx);
    e.sum_max  = MSL_CNT_W'(sm);
    e.rt_long  = MSL_GAP_W'(ta);
    e.rt_short = MSL_GAP_W'(tb);
    e.tr_long  = MSL_GAP_W'(ra);
    e.tr_short = MSL_GAP_W'(rb);
    return e;
  endfunction

  always_comb begin
    case (int'(class_code))
      2:       lim = mk(2, 1, 3, 3, 2, 3, 1);
      4:       lim = mk(3, 1, 4, 3, 1, 3, 1);
      8:       lim = mk(4, 1, 5, 3, 1, 2, 1);
      10:      lim = mk(4, 2, 5, 3, 1, 2, 1);
      12:      lim = mk(4, 4, 5, 2, 1, 2, 1);
      default: lim = '0;
    endcase
  end
endmodule

// File: rtl/msl_slot_align.sv
module msl_slot_align #(
  parameter int NSLOT = 8,
  parameter int SHIFT = 3
) (
  input  logic [NSLOT-1:0] ul_map,
  output logic [NSLOT-1:0] tl_map
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_pos
    assign tl_map[(k + SHIFT) % NSLOT] = ul_map[k];
  end
endmodule

// File: rtl/msl_gap_check.sv
module msl_gap_check #(
  parameter int NSLOT = 8,
  parameter int LW    = 3
) (
  input  logic [NSLOT-1:0] from_map,
  input  logic [NSLOT-1:0] to_map,
  input  logic [LW-1:0]    min_gap,
  output logic             too_close
);
  // A gap of g idle slots means distance g+1; any distance <= min_gap fails.
  always_comb begin
    too_close = 1'b0;
    for (int d = 0; d < NSLOT; d++) begin
      if (d <= int'(min_gap)) begin
        for (int i = 0; i < NSLOT; i++) begin
          if (from_map[i] && to_map[(i + d) % NSLOT]) too_close = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msl_alloc_check.sv
module msl_alloc_check
  import msl_pkg::*;
#(
  parameter int NSLOT    = MSL_SLOTS,
  parameter int UL_SHIFT = 3,
  parameter int NCELL    = 6,
  parameter int CW       = 5,
  localparam int SW      = $clog2(NSLOT),
  localparam int CIW     = $clog2(NCELL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [CW-1:0]    class_code,
  input  logic [NSLOT-1:0] rx_map,
  input  logic [NSLOT-1:0] tx_map,
  output logic             alloc_ok,
  output logic [V_W-1:0]   viol,
  output logic             no_window,
  output logic [SW-1:0]    meas_slot,
  output logic [CIW-1:0]   meas_cell
);
  msl_limits_t      lim;
  logic [NSLOT-1:0] tx_tl;
  logic [NSLOT-1:0] idle;
  logic [3:0]       close;
  logic [MSL_CNT_W-1:0] rx_cnt, tx_cnt;
  logic [MSL_CNT_W:0]   sum_cnt;

  logic             ok_d, win_d;
  logic [V_W-1:0]   viol_d;
  logic [SW-1:0]    slot_d;
  logic [CIW-1:0]   cell_d;

  msl_class_rom #(.CW(CW)) u_rom (.class_code(class_code), .lim(lim));

  msl_slot_align #(.NSLOT(NSLOT), .SHIFT(UL_SHIFT)) u_align (
    .ul_map(tx_map), .tl_map(tx_tl));

  // g 0: rx->tx short, 1: rx->tx long, 2: tx->rx short, 3: tx->rx long
  for (genvar g = 0; g < 4; g++) begin : g_gap
    logic [NSLOT-1:0]     src, dst;
    logic [MSL_GAP_W-1:0] lmt;
    if (g < 2) begin : g_rt
      assign src = rx_map;
      assign dst = tx_tl;
      assign lmt = (g == 0) ? lim.rt_short : lim.rt_long;
    end else begin : g_tr
      assign src = tx_tl;
      assign dst = rx_map;
      assign lmt = (g == 2) ? lim.tr_short : lim.tr_long;
    end
    msl_gap_check #(.NSLOT(NSLOT), .LW(MSL_GAP_W)) u_gap (
      .from_map(src), .to_map(dst), .min_gap(lmt), .too_close(close[g]));
  end

  assign idle    = ~(rx_map | tx_tl);
  assign rx_cnt  = msl_popcnt(rx_map);
  assign tx_cnt  = msl_popcnt(tx_tl);
  assign sum_cnt = {1'b0, rx_cnt} + {1'b0, tx_cnt};

  always_comb begin
    viol_d = '0;
    if (!lim.known) begin
      viol_d[V_CLS] = 1'b1;
    end else begin
      viol_d[V_RX]  = rx_cnt > lim.rx_max;
      viol_d[V_TX]  = tx_cnt > lim.tx_max;
      viol_d[V_SUM] = sum_cnt > {1'b0, lim.sum_max};
      viol_d[V_RT]  = close[0];
      viol_d[V_TR]  = close[2];
    end
    ok_d  = lim.known && (viol_d[V_TR:V_RX] == '0);
    win_d = lim.known && (|idle) &&
            ((!close[1] && !close[2]) || (!close[0] && !close[3]));
    slot_d = '0;
    if (win_d) begin
      for (int i = NSLOT - 1; i >= 0; i--) begin
        if (idle[i]) slot_d = SW'(i);
      end
    end
    cell_d = meas_cell;
    if (win_d) cell_d = (meas_cell == CIW'(NCELL - 1)) ? '0 : meas_cell + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_ok  <= 1'b0;
      viol      <= '0;
      no_window <= 1'b0;
      meas_slot <= '0;
      meas_cell <= '0;
    end else if (frame_stb) begin
      alloc_ok  <= ok_d;
      viol      <= viol_d;
      no_window <= !win_d;
      meas_slot <= slot_d;
      meas_cell <= cell_d;
    end
  end

  assert_badclass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol[V_CLS] |-> (!alloc_ok && no_window));
  assert_cell_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    meas_cell < CIW'(NCELL));
  assert_cell_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !win_d) |=> $stable(meas_cell));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(alloc_ok) && $stable(viol) && $stable(meas_slot)));
  assert_window_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_d |-> (!close[0] && !close[2]));
  assert_ok_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (viol == '0));
endmodule

// File: tb/msl_alloc_check_test.sv
`timescale 1ns/1ps
module msl_alloc_check_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [4:0] class_code = '0;
  logic [7:0] rx_map = '0, tx_map = '0;
  logic       alloc_ok, no_window;
  logic [5:0] viol;
  logic [2:0] meas_slot, meas_cell;

  int checks = 0, errs = 0;
  bit done = 0;
  int exp_cell = 0;

  always #2.5 clk = ~clk;

  msl_alloc_check uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .class_code(class_code),
    .rx_map(rx_map), .tx_map(tx_map), .alloc_ok(alloc_ok), .viol(viol),
    .no_window(no_window), .meas_slot(meas_slot), .meas_cell(meas_cell));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      if (errs < 40) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Smallest forward distance from any slot in a to any slot in b; 8 if none.
  function automatic int min_dist(input logic [7:0] a, input logic [7:0] b);
    int m = 8;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (a[i] && b[j] && ((j - i + 8) % 8) < m) m = (j - i + 8) % 8;
    return m;
  endfunction

  task automatic expect_for(input int cls, input logic [7:0] rx, input logic [7:0] tx,
                            output bit ok, output logic [5:0] v, output bit win,
                            output int slot);
    int rmx, tmx, smx, ta, tb, ra, rb, nr, nt, drt, dtr;
    bit known;
    logic [7:0] tt, idl;
    known = 1;
    case (cls)
      2:  begin rmx=2; tmx=1; smx=3; ta=3; tb=2; ra=3; rb=1; end
      4:  begin rmx=3; tmx=1; smx=4; ta=3; tb=1; ra=3; rb=1; end
      8:  begin rmx=4; tmx=1; smx=5; ta=3; tb=1; ra=2; rb=1; end
      10: begin rmx=4; tmx=2; smx=5; ta=3; tb=1; ra=2; rb=1; end
      12: begin rmx=4; tmx=4; smx=5; ta=2; tb=1; ra=2; rb=1; end
      default: begin known=0; rmx=0; tmx=0; smx=0; ta=0; tb=0; ra=0; rb=0; end
    endcase
    tt = {tx[4:0], tx[7:5]};  // R1: uplink slot k -> timeline (k+3) mod 8
    nr = $countones(rx); nt = $countones(tx);
    drt = min_dist(rx, tt); dtr = min_dist(tt, rx);
    idl = ~(rx | tt);
    v = '0;
    if (!known) v[5] = 1;
    else begin
      v[0] = nr > rmx; v[1] = nt > tmx; v[2] = (nr + nt) > smx;
      v[3] = drt <= tb; v[4] = dtr <= rb;
    end
    ok = known && (v[4:0] == 0);
    win = known && (idl != 0) && ((drt > ta && dtr > rb) || (drt > tb && dtr > ra));
    slot = 0;
    if (win) for (int i = 7; i >= 0; i--) if (idl[i]) slot = i;
  endtask

  task automatic frame(input int cls, input logic [7:0] rx, input logic [7:0] tx,
                       input string tag);
    bit ok, win; logic [5:0] v; int slot;
    expect_for(cls, rx, tx, ok, v, win, slot);
    @(negedge clk);
    class_code = 5'(cls); rx_map = rx; tx_map = tx; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (win) exp_cell = (exp_cell == 5) ? 0 : exp_cell + 1;
    chk({tag, " R10 alloc_ok"}, alloc_ok, ok);
    chk({tag, " R2 R3 R4 R5 R9 viol"}, viol, v);
    chk({tag, " R6 no_window"}, no_window, !win);
    chk({tag, " R7 meas_slot"}, meas_slot, slot);
    chk({tag, " R8 meas_cell"}, meas_cell, exp_cell);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    int cls_list[5] = '{2, 4, 8, 10, 12};
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset alloc_ok", alloc_ok, 0);
    chk("R11 reset viol", viol, 0);
    chk("R11 reset no_window", no_window, 0);
    chk("R11 reset meas_slot", meas_slot, 0);
    chk("R11 reset meas_cell", meas_cell, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: single slot pair, downlink 2 / uplink 2 -> timeline 5
    frame(4, 8'h04, 8'h04, "R1 single-slot c4");
    // R1: wrap, uplink 6 lands on timeline 1 right after rx 0
    frame(12, 8'h01, 8'h40, "R1 wrap c12");
    // R2/R3: class 10 over the sum limit
    frame(10, 8'h0F, 8'h03, "R3 sum c10");
    // R4: overlap of rx and tx on timeline
    frame(8, 8'h08, 8'h01, "R4 overlap c8");
    // R8: window every frame with empty maps, check the wrap
    for (int n = 0; n < 7; n++) frame(12, 8'h00, 8'h00, "R8 wrap");

    // R11: inputs change without strobe, outputs hold
    frame(2, 8'h01, 8'h01, "R11 base");
    begin
      logic [5:0] v0; logic o0, w0; logic [2:0] s0, c0;
      v0 = viol; o0 = alloc_ok; w0 = no_window; s0 = meas_slot; c0 = meas_cell;
      class_code = 5'd3; rx_map = 8'hFF; tx_map = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R11 hold viol", viol, v0);
      chk("R11 hold alloc_ok", alloc_ok, o0);
      chk("R11 hold no_window", no_window, w0);
      chk("R11 hold meas_slot", meas_slot, s0);
      chk("R11 hold meas_cell", meas_cell, c0);
    end

    // R9: every unsupported code
    for (int c = 0; c < 32; c++) begin
      if (c != 2 && c != 4 && c != 8 && c != 10 && c != 12) begin
        frame(c, 8'h01, 8'h01, "R9 bad class");
        frame(c, 8'h00, 8'h00, "R9 bad class empty");
      end
    end

    // Sweep: every rx bitmap against 16 tx bitmaps, per supported class
    foreach (cls_list[k]) begin
      for (int t = 0; t < 16; t++) begin
        for (int r = 0; r < 256; r++) begin
          frame(cls_list[k], 8'(r), 8'((t * 73 + (t >> 1)) & 255), "sweep");
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule